// File: doc/BRIEF.md
# Prioritised Interrupt Request Arbiter

This block sits beside a CPU sequencer. It watches one edge-triggered non-maskable request, a configurable number of level-sensitive maskable request lines (three by default), and an external bus request. On each end-of-instruction strobe it picks at most one source to serve. A pending bus request wins over everything. The non-maskable request comes next, then maskable line 0, line 1 and line 2, in that order. When an interrupt is chosen, the block raises an acknowledge request toward the sequencer and holds it until the sequencer reports the acknowledge cycle done. While it is raised, the block shows which source was chosen, whether the acknowledge cycle must drive the opcode-fetch and I/O-request strobes together (line 0 only, so a device can supply a vector), and the fixed restart address for the non-maskable case.

The block owns the global interrupt enable flag. The sequencer sets or clears it with one-cycle strobes, and the block clears it on its own when it accepts a maskable request. A falling edge on the non-maskable input is latched until it is served, so a pulse shorter than an instruction is not lost. The enable flag does not affect it.

The controller has three states. In IDLE it waits for a boundary. IDLE goes to BUS_HOLD when the bus request is active at a boundary. IDLE goes to ACK when any interrupt is selected at a boundary. BUS_HOLD returns to IDLE when the bus request is released. ACK returns to IDLE when ack_done is seen.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, ack_req is 0, src_sel is 0 (none), m1_iorq is 0, restart_addr is 0, ie_en is 0, and no non-maskable request is pending.
- R2: A decision is made only in IDLE, in a cycle where instr_end is 1. At most one source is accepted per boundary. ack_req rises in the cycle after the boundary and stays 1 until ack_done is sampled 1, then falls in the next cycle.
- R3: If busreq_n is 0 at a boundary, no interrupt is acknowledged. src_sel reads 1 (bus) and ack_req stays 0 until busreq_n returns to 1. A non-maskable request pending at that time stays pending.
- R4: A 1-to-0 transition of nmi_n is latched until it is accepted, even if nmi_n has returned high. One falling edge yields exactly one acknowledge, however long nmi_n stays low.
- R5: The non-maskable request is accepted whatever ie_en is, and accepting it leaves ie_en unchanged. During its acknowledge, src_sel is 2 and restart_addr is 0x0066. In every other cycle, restart_addr is 0.
- R6: Among interrupts, the non-maskable request (src 2) wins over maskable line 0 (src 3), which wins over line 1 (src 4), which wins over line 2 (src 5). A maskable line k requests when int_n[k] is 0 and reports src 3+k.
- R7: Maskable lines are ignored at a boundary while ie_en is 0.
- R8: ie_set makes ie_en 1 and ie_clr makes it 0 in the next cycle. Accepting a maskable request makes ie_en 0 in the same cycle ack_req rises, and this takes precedence over a simultaneous ie_set.
- R9: m1_iorq is 1 exactly during the acknowledge of maskable line 0. It is 0 for every other source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request, falling edge active |
| int_n | input | NUM_INT | Maskable request lines, active low level, bit 0 highest priority |
| busreq_n | input | 1 | External bus request, active low |
| instr_end | input | 1 | End-of-instruction strobe from the sequencer |
| ie_set | input | 1 | Strobe that sets the global enable |
| ie_clr | input | 1 | Strobe that clears the global enable |
| ack_done | input | 1 | Sequencer has finished the acknowledge cycle |
| src_sel | output | SRC_W | Selected source: 0 none, 1 bus, 2 NMI, 3+k maskable line k |
| ack_req | output | 1 | Acknowledge cycle requested |
| m1_iorq | output | 1 | Acknowledge cycle must drive fetch and I/O strobes together |
| restart_addr | output | ADDR_W | Restart address during the NMI acknowledge, else 0 |
| ie_en | output | 1 | Global interrupt enable flag |

## Verification
The hardest situation to reach is a non-maskable edge that arrives while the bus is held by an external master, and that must survive the hold and be served at the first boundary after release. The stimulus latches a one-cycle nmi_n pulse, holds busreq_n low across a boundary, and checks that src_sel shows the bus hold with no acknowledge. It then releases the bus and expects the NMI at the next boundary. A related case also needs precise timing: nmi_n is left low across two boundaries to confirm that a single edge gives a single acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // Source identifiers reported on src_sel
    localparam int SRC_NONE     = 0;
    localparam int SRC_BUS      = 1;
    localparam int SRC_NMI      = 2;
    localparam int SRC_INT_BASE = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_BUS_HOLD = 2'd1,
        ST_ACK      = 2'd2
    } arb_state_e;

    function automatic int src_width(input int num_int);
        return $clog2(num_int + SRC_INT_BASE);
    endfunction

endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pend
);

    logic nmi_prev;
    logic fall;

    assign fall = nmi_prev & ~nmi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b1;
            pend     <= 1'b0;
        end else begin
            nmi_prev <= nmi_n;
            if (fall)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_INT = 3,
    parameter int SRC_W   = irq_arb_pkg::src_width(NUM_INT)
) (
    input  logic               busreq,
    input  logic               nmi_pend,
    input  logic [NUM_INT-1:0] int_lvl,
    input  logic               ie,
    output logic [SRC_W-1:0]   pick
);
    import irq_arb_pkg::*;

    logic [NUM_INT-1:0] int_qual;

    generate
        for (genvar g = 0; g < NUM_INT; g++) begin : g_qual
            assign int_qual[g] = ie & int_lvl[g];
        end
    endgenerate

    always_comb begin
        pick = SRC_W'(SRC_NONE);
        // lowest index has highest priority: scan from the top down
        for (int i = NUM_INT - 1; i >= 0; i--) begin
            if (int_qual[i])
                pick = SRC_W'(SRC_INT_BASE + i);
        end
        if (nmi_pend)
            pick = SRC_W'(SRC_NMI);
        if (busreq)
            pick = SRC_W'(SRC_BUS);
    end

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm #(
    parameter int               NUM_INT = 3,
    parameter int               SRC_W   = irq_arb_pkg::src_width(NUM_INT),
    parameter int               ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = ADDR_W'(16'h0066)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_end,
    input  logic              busreq,
    input  logic              ack_done,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic [SRC_W-1:0]  pick,
    output logic              take_nmi,
    output logic [SRC_W-1:0]  src_sel,
    output logic              ack_req,
    output logic              m1_iorq,
    output logic [ADDR_W-1:0] restart_addr,
    output logic              ie_en
);
    import irq_arb_pkg::*;

    localparam logic [SRC_W-1:0] C_NONE = SRC_W'(SRC_NONE);
    localparam logic [SRC_W-1:0] C_BUS  = SRC_W'(SRC_BUS);
    localparam logic [SRC_W-1:0] C_NMI  = SRC_W'(SRC_NMI);
    localparam logic [SRC_W-1:0] C_INT0 = SRC_W'(SRC_INT_BASE);

    arb_state_e       state_q, state_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic             decide;
    logic             take_mask;

    assign decide    = (state_q == ST_IDLE) && instr_end;
    assign take_nmi  = decide && (pick == C_NMI);
    assign take_mask = decide && (pick >= C_INT0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_end) begin
                    if (pick == C_BUS) begin
                        state_d = ST_BUS_HOLD;
                    end else if (pick != C_NONE) begin
                        state_d = ST_ACK;
                        src_d   = pick;
                    end
                end
            end
            ST_BUS_HOLD: begin
                if (!busreq)
                    state_d = ST_IDLE;
            end
            ST_ACK: begin
                if (ack_done) begin
                    state_d = ST_IDLE;
                    src_d   = C_NONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and enable flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= C_NONE;
            ie_en   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            if (take_mask || ie_clr)
                ie_en <= 1'b0;
            else if (ie_set)
                ie_en <= 1'b1;
        end
    end

    // outputs decoded from the state
    always_comb begin
        src_sel      = C_NONE;
        ack_req      = 1'b0;
        m1_iorq      = 1'b0;
        restart_addr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUS_HOLD: src_sel = C_BUS;
            ST_ACK: begin
                src_sel = src_q;
                ack_req = 1'b1;
                m1_iorq = (src_q == C_INT0);
                if (src_q == C_NMI)
                    restart_addr = NMI_VEC;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int               NUM_INT = 3,
    parameter int               SRC_W   = irq_arb_pkg::src_width(NUM_INT),
    parameter int               ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = ADDR_W'(16'h0066)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_n,
    input  logic [NUM_INT-1:0] int_n,
    input  logic               busreq_n,
    input  logic               instr_end,
    input  logic               ie_set,
    input  logic               ie_clr,
    input  logic               ack_done,
    output logic [SRC_W-1:0]   src_sel,
    output logic               ack_req,
    output logic               m1_iorq,
    output logic [ADDR_W-1:0]  restart_addr,
    output logic               ie_en
);

    logic             nmi_pend;
    logic             take_nmi;
    logic [SRC_W-1:0] pick;

    irq_nmi_edge u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .take  (take_nmi),
        .pend  (nmi_pend)
    );

    irq_prio_pick #(.NUM_INT(NUM_INT), .SRC_W(SRC_W)) u_pick (
        .busreq   (~busreq_n),
        .nmi_pend (nmi_pend),
        .int_lvl  (~int_n),
        .ie       (ie_en),
        .pick     (pick)
    );

    irq_ack_fsm #(
        .NUM_INT (NUM_INT),
        .SRC_W   (SRC_W),
        .ADDR_W  (ADDR_W),
        .NMI_VEC (NMI_VEC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_end    (instr_end),
        .busreq       (~busreq_n),
        .ack_done     (ack_done),
        .ie_set       (ie_set),
        .ie_clr       (ie_clr),
        .pick         (pick),
        .take_nmi     (take_nmi),
        .src_sel      (src_sel),
        .ack_req      (ack_req),
        .m1_iorq      (m1_iorq),
        .restart_addr (restart_addr),
        .ie_en        (ie_en)
    );

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int NUM_INT = 3,
    parameter int SRC_W   = 3,
    parameter int ADDR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_end,
    input logic              busreq_n,
    input logic              ack_done,
    input logic              ie_set,
    input logic              ie_clr,
    input logic [SRC_W-1:0]  src_sel,
    input logic              ack_req,
    input logic              m1_iorq,
    input logic [ADDR_W-1:0] restart_addr,
    input logic              ie_en
);
    import irq_arb_pkg::*;

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_done) |=> ack_req); // R2
    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_req) |-> $past(instr_end)); // R2
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_done) |=> !ack_req); // R2
    AST_BUS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_W'(SRC_BUS)) |-> !ack_req); // R3
    AST_VEC_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_addr != '0) |-> (ack_req && src_sel == SRC_W'(SRC_NMI))); // R5
    AST_NMI_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_req) && src_sel == SRC_W'(SRC_NMI) && !$past(ie_set) && !$past(ie_clr))
        |-> (ie_en == $past(ie_en))); // R5
    AST_MASKED_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_req) && src_sel >= SRC_W'(SRC_INT_BASE)) |-> $past(ie_en)); // R7
    AST_MASK_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_req) && src_sel >= SRC_W'(SRC_INT_BASE)) |-> !ie_en); // R8
    AST_FLAG_INT0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        m1_iorq |-> (ack_req && src_sel == SRC_W'(SRC_INT_BASE))); // R9

endmodule

bind irq_arbiter irq_arbiter_chk #(
    .NUM_INT (NUM_INT),
    .SRC_W   (SRC_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_end    (instr_end),
    .busreq_n     (busreq_n),
    .ack_done     (ack_done),
    .ie_set       (ie_set),
    .ie_clr       (ie_clr),
    .src_sel      (src_sel),
    .ack_req      (ack_req),
    .m1_iorq      (m1_iorq),
    .restart_addr (restart_addr),
    .ie_en        (ie_en)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;

    localparam int NUM_INT = 3;
    localparam int SRC_W   = 3;
    localparam int ADDR_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               nmi_n = 1'b1;
    logic [NUM_INT-1:0] int_n = '1;
    logic               busreq_n = 1'b1;
    logic               instr_end = 1'b0;
    logic               ie_set = 1'b0;
    logic               ie_clr = 1'b0;
    logic               ack_done = 1'b0;
    logic [SRC_W-1:0]   src_sel;
    logic               ack_req;
    logic               m1_iorq;
    logic [ADDR_W-1:0]  restart_addr;
    logic               ie_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        string            req;
        logic [SRC_W-1:0] src;
        logic             flag;
        logic [15:0]      addr;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n),
        .busreq_n(busreq_n), .instr_end(instr_end), .ie_set(ie_set),
        .ie_clr(ie_clr), .ack_done(ack_done), .src_sel(src_sel),
        .ack_req(ack_req), .m1_iorq(m1_iorq), .restart_addr(restart_addr),
        .ie_en(ie_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // driver: one instruction boundary, optionally expecting an acknowledge
    task automatic boundary(input string req, input bit want, input int src,
                            input bit flag, input logic [15:0] addr);
        exp_t e;
        if (want) begin
            e.req = req; e.src = SRC_W'(src); e.flag = flag; e.addr = addr;
            sb_q.push_back(e);
        end
        @(negedge clk) instr_end = 1'b1;
        @(negedge clk) instr_end = 1'b0;
        if (!want)
            check({req, " no ack"}, {31'b0, ack_req}, 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe_ie(input bit set);
        @(negedge clk) begin ie_set = set; ie_clr = !set; end
        @(negedge clk) begin ie_set = 1'b0; ie_clr = 1'b0; end
    endtask

    task automatic nmi_pulse();
        @(negedge clk) nmi_n = 1'b0;
        @(negedge clk) nmi_n = 1'b1;
    endtask

    // monitor: compares each acknowledge with the scoreboard and answers it
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ack_req && !ack_done) begin
                if (sb_q.size() == 0) begin
                    check("R2 unexpected ack", {29'b0, src_sel}, 32'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.req, {12'b0, src_sel, m1_iorq, restart_addr},
                                 {12'b0, e.src, e.flag, e.addr});
                end
                ack_done = 1'b1;
            end else begin
                ack_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 ack_req", {31'b0, ack_req}, 32'd0);
        check("R1 src_sel", {29'b0, src_sel}, 32'd0);
        check("R1 restart", {16'b0, restart_addr}, 32'd0);
        check("R1 ie_en",   {31'b0, ie_en}, 32'd0);
        check("R1 m1_iorq", {31'b0, m1_iorq}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1: no stale NMI after reset; empty boundary gives nothing
        boundary("R1 idle boundary", 0, 0, 0, 16'h0);

        // R7 masked line ignored while enable is 0
        int_n = 3'b101;
        boundary("R7 masked", 0, 0, 0, 16'h0);

        // R8 set strobe, R6 line1 over line2, R8 clear on accept
        strobe_ie(1'b1);
        check("R8 ie_set", {31'b0, ie_en}, 32'd1);
        int_n = 3'b001;
        boundary("R6 int1 over int2", 1, 4, 0, 16'h0);
        check("R8 cleared by accept", {31'b0, ie_en}, 32'd0);
        boundary("R7 int2 masked after accept", 0, 0, 0, 16'h0);
        strobe_ie(1'b1);
        int_n = 3'b011;
        boundary("R6 int2 alone", 1, 5, 0, 16'h0);

        // R8 explicit clear strobe
        strobe_ie(1'b1);
        strobe_ie(1'b0);
        check("R8 ie_clr", {31'b0, ie_en}, 32'd0);
        boundary("R8 cleared blocks int2", 0, 0, 0, 16'h0);

        // R9 line 0 wins and flags the vector cycle
        strobe_ie(1'b1);
        int_n = 3'b100;
        boundary("R9 int0 over int1", 1, 3, 1, 16'h0);
        int_n = 3'b111;

        // R5 NMI with enable 0 and with enable 1, enable left alone
        nmi_pulse();
        boundary("R5 nmi with ie=0", 1, 2, 0, 16'h0066);
        check("R5 ie stays 0", {31'b0, ie_en}, 32'd0);
        strobe_ie(1'b1);
        int_n = 3'b110;
        nmi_pulse();
        boundary("R6 nmi over int0", 1, 2, 0, 16'h0066);
        check("R5 ie stays 1", {31'b0, ie_en}, 32'd1);
        boundary("R6 int0 after nmi", 1, 3, 1, 16'h0);
        int_n = 3'b111;

        // R4 held low: single edge, single acknowledge
        @(negedge clk) nmi_n = 1'b0;
        repeat (4) @(negedge clk);
        boundary("R4 held nmi first", 1, 2, 0, 16'h0066);
        boundary("R4 held nmi no repeat", 0, 0, 0, 16'h0);
        @(negedge clk) nmi_n = 1'b1;

        // R3 bus request over a pending NMI
        nmi_pulse();
        busreq_n = 1'b0;
        boundary("R3 bus hold", 0, 0, 0, 16'h0);
        check("R3 src bus", {29'b0, src_sel}, 32'd1);
        check("R5 no vector in hold", {16'b0, restart_addr}, 32'd0);
        @(negedge clk) busreq_n = 1'b1;
        @(negedge clk);
        check("R3 hold released", {29'b0, src_sel}, 32'd0);
        boundary("R3 nmi kept through hold", 1, 2, 0, 16'h0066);

        // R2 only at boundaries: requests with no strobe give nothing
        strobe_ie(1'b1);
        int_n = 3'b110;
        repeat (4) @(negedge clk);
        check("R2 no ack without boundary", {31'b0, ack_req}, 32'd0);
        boundary("R2 boundary takes int0", 1, 3, 1, 16'h0);
        int_n = 3'b111;

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb_q.size(), 32'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule